// File: doc/BRIEF.md
# ATA PIO Timing-to-Clock Converter

This block turns the PIO transfer modes of the two drives on one ATA channel into the clock counts that a programmable cycle timer needs. Each drive has a 3-bit mode code: PIO 0 to 4, or a code that marks the drive as not fitted. A strap bit picks one of two bus clock rates. For each drive, the block looks up the standard address-setup, active-pulse and full-cycle times in nanoseconds. It derives the recovery time from them and converts every time to a count of bus clocks, rounding up. Each count is then clamped to the range its timer field can hold.

The two drives share one address-setup field but keep separate active and recovery fields. The shared setup count is therefore the larger of the two drives' setup counts. With that value the slower drive's setup is always met. The block also packs the counts into the timer's register byte layout. Software or a sequencer writes those bytes out; this block does not.

A request is a one-cycle `inValid` pulse. The converted results appear on registered outputs in the next cycle, together with a one-cycle `outValid` pulse. The results then hold until the next request.

Top module: `pio_timing_conv`

## Requirements
- R1: After reset, `outValid` is 0, both active counts are 1, both recovery counts are 2, the shared setup count is 1, and all three bytes are 0x00.
- R2: A request sampled with `inValid` high at a clock edge updates every result output at that edge. `outValid` is 1 for exactly the cycle after each request and 0 otherwise.
- R3: While `inValid` is low, changes on the mode and strap inputs leave every result output unchanged.
- R4: Mode codes 0 to 4 select PIO 0 to 4. Codes 5, 6 and 7 mark the drive absent. An absent drive gives active 1 and recovery 2, and contributes a setup count of 1.
- R5: A time t in ns becomes clocks as ceil(t*f/1000) for a bus clock of f MHz. The table (setup/active/cycle ns) is: PIO0 70/165/600, PIO1 50/125/383, PIO2 30/100/240, PIO3 30/80/180, PIO4 25/70/120.
- R6: The recovery time in ns is the cycle time minus the setup time minus the active time, taken before conversion to clocks.
- R7: The setup count is held within 1..4, the active count within 1..16 and the recovery count within 2..17. For example, PIO 4 at 33 MHz converts recovery to 1 clock, which is raised to 2.
- R8: The shared setup count is the maximum of the two drives' setup counts.
- R9: `strap25` high selects a 25 MHz bus clock and low selects 33 MHz.
- R10: Each drive's cycle byte holds active-1 in bits 7:4 and recovery-2 in bits 3:0. The misc byte holds shared setup-1 in bits 7:4, and bits 3:0 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Request strobe; mode and strap inputs are sampled while it is high |
| modeA | input | 3 | Drive 0 mode code (0..4 PIO, 5..7 absent) |
| modeB | input | 3 | Drive 1 mode code (0..4 PIO, 5..7 absent) |
| strap25 | input | 1 | 1 selects 25 MHz, 0 selects 33 MHz |
| outValid | output | 1 | One-cycle pulse marking fresh results |
| activeA | output | 5 | Drive 0 active-pulse count |
| recoveryA | output | 5 | Drive 0 recovery count |
| activeB | output | 5 | Drive 1 active-pulse count |
| recoveryB | output | 5 | Drive 1 recovery count |
| setupShared | output | 5 | Shared address-setup count |
| cycleByteA | output | 8 | Drive 0 encoded cycle byte |
| cycleByteB | output | 8 | Drive 1 encoded cycle byte |
| miscByte | output | 8 | Encoded shared-setup byte |

## Verification
The recovery clamp and the shared-setup maximum can act on the same request. An example is drive 0 at PIO 4 paired with drive 1 at PIO 0, both at 33 MHz. In one cycle, drive 0's recovery is raised from 1 to 2 clocks while the shared setup count is taken from drive 1's 3 clocks. The stimulus table also pairs an absent drive with a present one, so the absent minima and the maximum meet in one request. Every output of each such request is checked against values worked out by hand from the timing table.

// File: rtl/pio_conv_pkg.sv
package pio_conv_pkg;

  // Highest mode code that names a real PIO mode; codes above it mean "absent".
  localparam int PIO_TOP_MODE = 4;

  // Legal ranges of the timer fields
  localparam int SETUP_LO = 1;
  localparam int SETUP_HI = 4;
  localparam int ACT_LO   = 1;
  localparam int ACT_HI   = 16;
  localparam int REC_LO   = 2;
  localparam int REC_HI   = 17;

  typedef struct packed {
    logic capture;  // take a new request this cycle
    logic sel25;    // use the slower bus clock
  } ctlStrobe_t;

  typedef struct packed {
    logic [15:0] setupNs;
    logic [15:0] activeNs;
    logic [15:0] cycleNs;
  } pioNs_t;

  function automatic pioNs_t pioTiming(input logic [2:0] mode);
    pioNs_t t;
    case (mode)
      3'd0:    t = '{setupNs: 16'd70, activeNs: 16'd165, cycleNs: 16'd600};
      3'd1:    t = '{setupNs: 16'd50, activeNs: 16'd125, cycleNs: 16'd383};
      3'd2:    t = '{setupNs: 16'd30, activeNs: 16'd100, cycleNs: 16'd240};
      3'd3:    t = '{setupNs: 16'd30, activeNs: 16'd80,  cycleNs: 16'd180};
      3'd4:    t = '{setupNs: 16'd25, activeNs: 16'd70,  cycleNs: 16'd120};
      default: t = '{setupNs: 16'd0,  activeNs: 16'd0,   cycleNs: 16'd0};
    endcase
    return t;
  endfunction

  // Round-up conversion of nanoseconds to clocks at mhz MHz
  function automatic int nsToClk(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int clampTo(input int v, input int lo, input int hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

endpackage

// File: rtl/pio_drive_calc.sv
module pio_drive_calc
  import pio_conv_pkg::*;
#(
  parameter int FAST_MHZ = 33,
  parameter int SLOW_MHZ = 25,
  parameter int CNT_W    = 5
) (
  input  logic [2:0]       modeCode,
  input  logic             sel25,
  output logic [CNT_W-1:0] setupCnt,
  output logic [CNT_W-1:0] activeCnt,
  output logic [CNT_W-1:0] recoveryCnt
);

  pioNs_t tNs;
  int     mhz;
  int     setupNs;
  int     activeNs;
  int     recoveryNs;

  always_comb begin
    tNs        = pioTiming(modeCode);
    mhz        = sel25 ? SLOW_MHZ : FAST_MHZ;
    setupNs    = int'(tNs.setupNs);
    activeNs   = int'(tNs.activeNs);
    recoveryNs = int'(tNs.cycleNs) - setupNs - activeNs;
    if (int'(modeCode) > PIO_TOP_MODE) begin
      setupCnt    = CNT_W'(SETUP_LO);
      activeCnt   = CNT_W'(ACT_LO);
      recoveryCnt = CNT_W'(REC_LO);
    end else begin
      setupCnt    = CNT_W'(clampTo(nsToClk(setupNs, mhz), SETUP_LO, SETUP_HI));
      activeCnt   = CNT_W'(clampTo(nsToClk(activeNs, mhz), ACT_LO, ACT_HI));
      recoveryCnt = CNT_W'(clampTo(nsToClk(recoveryNs, mhz), REC_LO, REC_HI));
    end
  end

endmodule

// File: rtl/pio_conv_ctrl.sv
module pio_conv_ctrl
  import pio_conv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       strap25,
  output ctlStrobe_t ctl,
  output logic       outValid
);

  always_comb begin
    ctl.capture = inValid;
    ctl.sel25   = strap25;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

endmodule

// File: rtl/pio_conv_datapath.sv
module pio_conv_datapath
  import pio_conv_pkg::*;
#(
  parameter int FAST_MHZ = 33,
  parameter int SLOW_MHZ = 25,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobe_t       ctl,
  input  logic [2:0]       modeA,
  input  logic [2:0]       modeB,
  output logic [CNT_W-1:0] activeA,
  output logic [CNT_W-1:0] recoveryA,
  output logic [CNT_W-1:0] activeB,
  output logic [CNT_W-1:0] recoveryB,
  output logic [CNT_W-1:0] setupShared,
  output logic [7:0]       cycleByteA,
  output logic [7:0]       cycleByteB,
  output logic [7:0]       miscByte
);

  localparam int NUM_DRV = 2;

  logic [NUM_DRV-1:0][2:0] modeVec;
  logic [CNT_W-1:0] setupC [NUM_DRV];
  logic [CNT_W-1:0] actC   [NUM_DRV];
  logic [CNT_W-1:0] recC   [NUM_DRV];
  logic [CNT_W-1:0] actR   [NUM_DRV];
  logic [CNT_W-1:0] recR   [NUM_DRV];
  logic [CNT_W-1:0] setupMax;
  logic [CNT_W-1:0] setupR;
  logic [7:0]       cycB   [NUM_DRV];

  assign modeVec = {modeB, modeA};

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
    pio_drive_calc #(
      .FAST_MHZ(FAST_MHZ),
      .SLOW_MHZ(SLOW_MHZ),
      .CNT_W   (CNT_W)
    ) calc_i (
      .modeCode   (modeVec[d]),
      .sel25      (ctl.sel25),
      .setupCnt   (setupC[d]),
      .activeCnt  (actC[d]),
      .recoveryCnt(recC[d])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        actR[d] <= CNT_W'(ACT_LO);
        recR[d] <= CNT_W'(REC_LO);
      end else if (ctl.capture) begin
        actR[d] <= actC[d];
        recR[d] <= recC[d];
      end
    end

    assign cycB[d] = {4'(actR[d] - CNT_W'(ACT_LO)), 4'(recR[d] - CNT_W'(REC_LO))};
  end

  always_comb begin
    setupMax = setupC[0];
    for (int d = 1; d < NUM_DRV; d++) begin
      if (setupC[d] > setupMax) setupMax = setupC[d];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           setupR <= CNT_W'(SETUP_LO);
    else if (ctl.capture) setupR <= setupMax;
  end

  assign activeA     = actR[0];
  assign recoveryA   = recR[0];
  assign activeB     = actR[1];
  assign recoveryB   = recR[1];
  assign setupShared = setupR;
  assign cycleByteA  = cycB[0];
  assign cycleByteB  = cycB[1];
  assign miscByte    = {4'(setupR - CNT_W'(SETUP_LO)), 4'b0000};

endmodule

// File: rtl/pio_timing_conv.sv
module pio_timing_conv
  import pio_conv_pkg::*;
#(
  parameter int FAST_MHZ = 33,
  parameter int SLOW_MHZ = 25,
  parameter int CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic [2:0]       modeA,
  input  logic [2:0]       modeB,
  input  logic             strap25,
  output logic             outValid,
  output logic [CNT_W-1:0] activeA,
  output logic [CNT_W-1:0] recoveryA,
  output logic [CNT_W-1:0] activeB,
  output logic [CNT_W-1:0] recoveryB,
  output logic [CNT_W-1:0] setupShared,
  output logic [7:0]       cycleByteA,
  output logic [7:0]       cycleByteB,
  output logic [7:0]       miscByte
);

  ctlStrobe_t ctl;

  pio_conv_ctrl ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .strap25 (strap25),
    .ctl     (ctl),
    .outValid(outValid)
  );

  pio_conv_datapath #(
    .FAST_MHZ(FAST_MHZ),
    .SLOW_MHZ(SLOW_MHZ),
    .CNT_W   (CNT_W)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl        (ctl),
    .modeA      (modeA),
    .modeB      (modeB),
    .activeA    (activeA),
    .recoveryA  (recoveryA),
    .activeB    (activeB),
    .recoveryB  (recoveryB),
    .setupShared(setupShared),
    .cycleByteA (cycleByteA),
    .cycleByteB (cycleByteB),
    .miscByte   (miscByte)
  );

endmodule

// File: rtl/pio_conv_chk.sv
module pio_conv_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic [2:0]       modeA,
  input logic             outValid,
  input logic [CNT_W-1:0] activeA,
  input logic [CNT_W-1:0] recoveryA,
  input logic [CNT_W-1:0] activeB,
  input logic [CNT_W-1:0] recoveryB,
  input logic [CNT_W-1:0] setupShared
);

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ($stable(activeA) && $stable(recoveryA) && $stable(activeB)
                  && $stable(recoveryB) && $stable(setupShared)));

  // R4
  absent_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && modeA > 3'd4) |=> (activeA == CNT_W'(1) && recoveryA == CNT_W'(2)));

  // R7
  setup_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (setupShared >= CNT_W'(1) && setupShared <= CNT_W'(4)));

  // R7
  active_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (activeA >= CNT_W'(1) && activeA <= CNT_W'(16)
                  && activeB >= CNT_W'(1) && activeB <= CNT_W'(16)));

  // R7
  recovery_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (recoveryA >= CNT_W'(2) && recoveryA <= CNT_W'(17)
                  && recoveryB >= CNT_W'(2) && recoveryB <= CNT_W'(17)));

endmodule

bind pio_timing_conv pio_conv_chk #(.CNT_W(CNT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .inValid    (inValid),
  .modeA      (modeA),
  .outValid   (outValid),
  .activeA    (activeA),
  .recoveryA  (recoveryA),
  .activeB    (activeB),
  .recoveryB  (recoveryB),
  .setupShared(setupShared)
);

// File: tb/pio_timing_conv_tb_top.sv
module pio_timing_conv_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inValid = 1'b0;
  logic [2:0] modeA = 3'd0;
  logic [2:0] modeB = 3'd0;
  logic       strap25 = 1'b0;
  logic       outValid;
  logic [4:0] activeA, recoveryA, activeB, recoveryB, setupShared;
  logic [7:0] cycleByteA, cycleByteB, miscByte;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pio_timing_conv dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .modeA(modeA), .modeB(modeB),
    .strap25(strap25), .outValid(outValid), .activeA(activeA), .recoveryA(recoveryA),
    .activeB(activeB), .recoveryB(recoveryB), .setupShared(setupShared),
    .cycleByteA(cycleByteA), .cycleByteB(cycleByteB), .miscByte(miscByte)
  );

  // Fields, 8 bits each: modeA, modeB, strap25, actA, recA, actB, recB, setup
  localparam int NVEC = 10;
  localparam logic [63:0] VEC [NVEC] = '{
    64'h00_00_00_06_0D_06_0D_03,
    64'h04_04_00_03_02_03_02_01,
    64'h04_00_00_03_02_06_0D_03,
    64'h01_03_01_04_06_02_02_02,
    64'h07_02_00_01_02_04_04_01,
    64'h07_07_01_01_02_01_02_01,
    64'h02_01_00_04_04_05_07_02,
    64'h00_04_01_05_0A_02_02_02,
    64'h03_05_00_03_03_01_02_01,
    64'h01_00_01_04_06_05_0A_02
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag, input int eAa, input int eRa, input int eAb,
                          input int eRb, input int eSu);
    check({"R5 ", tag}, "activeA", int'(activeA), eAa);
    check({"R6 ", tag}, "recoveryA", int'(recoveryA), eRa);
    check({"R5 ", tag}, "activeB", int'(activeB), eAb);
    check({"R6 ", tag}, "recoveryB", int'(recoveryB), eRb);
    check({"R8 ", tag}, "setupShared", int'(setupShared), eSu);
    check({"R10 ", tag}, "cycleByteA", int'(cycleByteA), ((eAa - 1) << 4) | (eRa - 2));
    check({"R10 ", tag}, "cycleByteB", int'(cycleByteB), ((eAb - 1) << 4) | (eRb - 2));
    check({"R10 ", tag}, "miscByte", int'(miscByte), (eSu - 1) << 4);
  endtask

  task automatic request(input logic [2:0] a, input logic [2:0] b, input logic s);
    @(negedge clk);
    modeA = a; modeB = b; strap25 = s; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R2", "outValid after request", int'(outValid), 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "outValid", int'(outValid), 0);
    checkAll("R1 reset", 1, 2, 1, 2, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "outValid idle", int'(outValid), 0);

    for (int i = 0; i < NVEC; i++) begin
      request(VEC[i][58:56], VEC[i][50:48], VEC[i][40]);
      checkAll($sformatf("vec%0d", i), int'(VEC[i][39:32]), int'(VEC[i][31:24]),
               int'(VEC[i][23:16]), int'(VEC[i][15:8]), int'(VEC[i][7:0]));
    end

    // R2: pulse lasts one cycle
    @(negedge clk);
    check("R2", "outValid falls", int'(outValid), 0);

    // R3: inputs change without a request; last results (vec9) must hold
    modeA = 3'd4; modeB = 3'd4; strap25 = 1'b0;
    repeat (3) @(negedge clk);
    check("R3", "outValid idle", int'(outValid), 0);
    checkAll("R3 hold", 4, 6, 5, 10, 2);

    // R7: PIO4 at 33 MHz, recovery 1 raised to 2
    request(3'd4, 3'd3, 1'b0);
    check("R7", "recoveryA clamp", int'(recoveryA), 2);
    check("R7", "recoveryB", int'(recoveryB), 3);

    // R4: code 6 is absent on drive B
    request(3'd0, 3'd6, 1'b0);
    check("R4", "activeB absent", int'(activeB), 1);
    check("R4", "recoveryB absent", int'(recoveryB), 2);
    check("R8", "setup from A", int'(setupShared), 3);

    // R9: same modes, strap selects clock rate
    request(3'd0, 3'd0, 1'b1);
    check("R9", "activeA 25MHz", int'(activeA), 5);
    check("R9", "recoveryA 25MHz", int'(recoveryA), 10);
    request(3'd0, 3'd0, 1'b0);
    check("R9", "activeA 33MHz", int'(activeA), 6);
    check("R9", "recoveryA 33MHz", int'(recoveryA), 13);

    // back-to-back requests
    @(negedge clk);
    modeA = 3'd2; modeB = 3'd2; strap25 = 1'b1; inValid = 1'b1;
    @(negedge clk);
    modeA = 3'd1; modeB = 3'd1; strap25 = 1'b0;
    check("R2", "b2b first activeA", int'(activeA), 3);
    @(negedge clk);
    inValid = 1'b0;
    check("R2", "b2b second activeA", int'(activeA), 5);
    check("R2", "b2b outValid", int'(outValid), 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule